// File: doc/BRIEF.md
# Character Attribute Pixel Processor

This block turns one fetched character cell into a serial pixel stream for a dot-matrix LCD. Each cell arrives as a 16-bit memory word: the low byte is the font row for the current raster line, and the high byte is either an attribute code or a second byte of bitmap graphics. Mode inputs choose between character and graphic operation, enable attribute handling, enable blinking, select an OR merge of font dots with bitmap data, and switch the display on or off.

In character mode the block applies four steps in a fixed order. Nondisplay comes first and forces the row light or dark. Blink blanking comes second. Reverse video comes third. The cursor comes last and is an XOR over the row. The result is 8 pixels, shifted out MSB first at one pixel per clock. In graphic mode the whole 16-bit word is shifted out as it stands. A frame tick input drives an internal counter. That counter supplies a fast blink phase and a slow blink phase. Address generation and LCD drive timing sit outside this block, so the cursor position match arrives from upstream as a per-cell hit flag.

Top module: `cattr_pixel_proc`

## Requirements
- R1: After reset `pix_valid_o` and `pix_o` are low, and the blink counter is zero. The first cell with blinking enabled therefore shows its dots.
- R2: In character mode a load presents 8 pixels, font bit 7 first, one per clock. The first pixel appears in the cycle after the load. `pix_valid_o` is high for exactly those cycles, and `pix_o` is low whenever it is low.
- R3: In graphic mode a load presents 16 pixels from `md_i[15]` down to `md_i[0]`. No attribute or cursor is applied.
- R4: Attribute bit 3 forces the row dark (all ones). Attribute bit 2 forces it light (all zeros). When both are set, bit 3 wins.
- R5: Attribute bit 1 blanks the row to light when `blink_en_i` is high and the slow phase is 1. When `blink_en_i` is low, the row is shown steadily. Blanking comes after nondisplay and before reverse.
- R6: Attribute bit 0 inverts the row after the nondisplay and blink steps.
- R7: When `attr_en_i` is low, the attribute byte has no effect in character mode.
- R8: With `or_mode_i` high in character mode, the row is the font byte ORed with the high byte, and no attribute is applied.
- R9: The cursor inverts the whole row when all of these hold: `cur_on_i` is high, `cur_hit_i` is high, and `cur_top_i <= raster_i <= cur_bot_i`. When top is greater than bottom, no cursor is shown.
- R10: `cur_mode_i` sets cursor visibility. 0 is steady. 1 is hidden. 2 is visible while the fast phase is 0. 3 is visible while the slow phase is 0. The fast and slow phases are bits FAST_BIT and SLOW_BIT of the count of frame ticks.
- R11: With `disp_on_i` low, every pixel of the cell is 0 in every mode, and the pixels still arrive with `pix_valid_o` high.
- R12: A load in the cycle that presents a cell's last pixel makes the next cell's first pixel appear in the following cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_load_i | input | 1 | Capture `md_i` and the controls, and start a cell |
| md_i | input | 2*DOTS | Low byte is font row; high byte is attribute or bitmap |
| disp_on_i | input | 1 | Display enable |
| graphic_i | input | 1 | 1 = graphic (16-pixel raw) mode |
| or_mode_i | input | 1 | Merge font with high-byte bitmap |
| attr_en_i | input | 1 | Attribute decode enable |
| blink_en_i | input | 1 | Attribute blink enable |
| frame_tick_i | input | 1 | One pulse per frame, advances blink counter |
| cur_on_i | input | 1 | Cursor enable |
| cur_hit_i | input | 1 | This cell is at the cursor position |
| cur_mode_i | input | 2 | Cursor blink mode |
| cur_top_i | input | RASTER_W | First cursor raster line |
| cur_bot_i | input | RASTER_W | Last cursor raster line |
| raster_i | input | RASTER_W | Current raster line within the character |
| pix_o | output | 1 | Serial pixel, 1 = dark |
| pix_valid_o | output | 1 | Pixel valid |

## Verification
The bench builds the block with FAST_BIT=1, SLOW_BIT=2 and RASTER_W=3. With these values both blink phases cycle within 8 frame ticks, and every raster line of an 8-line cell is reachable. The bench sweeps all 16 low attribute codes against every blink phase, attribute enable and blink enable. It sweeps all four cursor modes against every raster line for ordinary, single-line and inverted windows. Back-to-back loads are run throughout, so gapless streaming is exercised in both cell widths.

// File: rtl/cattr_pkg.sv
package cattr_pkg;
  typedef struct packed {
    logic hide_dark;
    logic hide_light;
    logic blink;
    logic reverse;
  } attr_t;

  typedef enum logic [1:0] {
    CUR_STEADY = 2'd0,
    CUR_HIDDEN = 2'd1,
    CUR_FAST   = 2'd2,
    CUR_SLOW   = 2'd3
  } cur_mode_e;
endpackage

// File: rtl/cattr_blink_timer.sv
module cattr_blink_timer #(
  parameter int FAST_BIT = 4,
  parameter int SLOW_BIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic fast_off_o,
  output logic slow_off_o
);
  localparam int CNT_W = ((FAST_BIT > SLOW_BIT) ? FAST_BIT : SLOW_BIT) + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign fast_off_o = cnt_q[FAST_BIT];
  assign slow_off_o = cnt_q[SLOW_BIT];

  // R10: counter moves only on a tick, by one
  a_r10_tick_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r10_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/cattr_cursor.sv
module cattr_cursor
  import cattr_pkg::*;
#(
  parameter int RASTER_W = 5
) (
  input  logic                on_i,
  input  logic                hit_i,
  input  logic [RASTER_W-1:0] raster_i,
  input  logic [RASTER_W-1:0] top_i,
  input  logic [RASTER_W-1:0] bot_i,
  input  cur_mode_e           mode_i,
  input  logic                fast_off_i,
  input  logic                slow_off_i,
  output logic                vis_o
);
  logic in_window;
  logic phase_ok;

  // an inverted window (top > bot) is empty
  assign in_window = (raster_i >= top_i) && (raster_i <= bot_i);

  always_comb begin
    unique case (mode_i)
      CUR_STEADY: phase_ok = 1'b1;
      CUR_HIDDEN: phase_ok = 1'b0;
      CUR_FAST:   phase_ok = !fast_off_i;
      CUR_SLOW:   phase_ok = !slow_off_i;
      default:    phase_ok = 1'b0;
    endcase
  end

  assign vis_o = on_i && hit_i && in_window && phase_ok;
endmodule

// File: rtl/cattr_cell_logic.sv
module cattr_cell_logic
  import cattr_pkg::*;
#(
  parameter int DOTS = 8
) (
  input  logic [DOTS-1:0]   font_i,
  input  logic [DOTS-1:0]   upper_i,
  input  logic              disp_on_i,
  input  logic              graphic_i,
  input  logic              or_mode_i,
  input  logic              attr_en_i,
  input  logic              blink_en_i,
  input  logic              blink_off_i,
  input  logic              cursor_i,
  output logic [2*DOTS-1:0] word_o,
  output logic              wide_o
);
  attr_t       attr;
  logic        hide_any;
  logic        hide_val;
  logic        blank;
  logic [DOTS-1:0] row;

  assign attr     = (attr_en_i && !or_mode_i) ? attr_t'(upper_i[3:0]) : '0;
  assign hide_any = attr.hide_dark || attr.hide_light;
  assign hide_val = attr.hide_dark;
  assign blank    = attr.blink && blink_en_i && blink_off_i;

  // nondisplay -> blink -> reverse -> cursor, per dot
  for (genvar d = 0; d < DOTS; d++) begin : g_dot
    logic base_dot, s_hide, s_blink, s_rev;
    assign base_dot = or_mode_i ? (font_i[d] | upper_i[d]) : font_i[d];
    assign s_hide   = hide_any ? hide_val : base_dot;
    assign s_blink  = blank ? 1'b0 : s_hide;
    assign s_rev    = s_blink ^ attr.reverse;
    assign row[d]   = disp_on_i & (s_rev ^ cursor_i);
  end

  always_comb begin
    if (graphic_i) word_o = disp_on_i ? {upper_i, font_i} : '0;
    else           word_o = {row, {DOTS{1'b0}}};
  end

  assign wide_o = graphic_i;
endmodule

// File: rtl/cattr_shifter.sv
module cattr_shifter #(
  parameter int WORD_W    = 16,
  parameter int SHORT_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pix_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= word_i;
      left_q  <= wide_i ? CNT_W'(WORD_W - 1) : CNT_W'(SHORT_LEN - 1);
      valid_q <= 1'b1;
    end else if (valid_q) begin
      sh_q <= sh_q << 1;
      if (left_q == '0) valid_q <= 1'b0;
      else              left_q  <= left_q - CNT_W'(1);
    end
  end

  assign pix_o   = valid_q & sh_q[WORD_W-1];
  assign valid_o = valid_q;

  a_r2_run_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && left_q != '0 |=> valid_q);
  a_r2_run_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && left_q == '0 && !load_i |=> !valid_q);
  a_r12_load_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_q);
endmodule

// File: rtl/cattr_pixel_proc.sv
module cattr_pixel_proc
  import cattr_pkg::*;
#(
  parameter int DOTS     = 8,
  parameter int RASTER_W = 5,
  parameter int FAST_BIT = 4,
  parameter int SLOW_BIT = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cell_load_i,
  input  logic [2*DOTS-1:0]   md_i,
  input  logic                disp_on_i,
  input  logic                graphic_i,
  input  logic                or_mode_i,
  input  logic                attr_en_i,
  input  logic                blink_en_i,
  input  logic                frame_tick_i,
  input  logic                cur_on_i,
  input  logic                cur_hit_i,
  input  logic [1:0]          cur_mode_i,
  input  logic [RASTER_W-1:0] cur_top_i,
  input  logic [RASTER_W-1:0] cur_bot_i,
  input  logic [RASTER_W-1:0] raster_i,
  output logic                pix_o,
  output logic                pix_valid_o
);
  localparam int WORD_W = 2 * DOTS;

  logic              fast_off, slow_off;
  logic              cur_vis;
  logic [WORD_W-1:0] word;
  logic              wide;

  cattr_blink_timer #(.FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (frame_tick_i),
    .fast_off_o (fast_off),
    .slow_off_o (slow_off)
  );

  cattr_cursor #(.RASTER_W(RASTER_W)) i_cursor (
    .on_i       (cur_on_i),
    .hit_i      (cur_hit_i),
    .raster_i   (raster_i),
    .top_i      (cur_top_i),
    .bot_i      (cur_bot_i),
    .mode_i     (cur_mode_e'(cur_mode_i)),
    .fast_off_i (fast_off),
    .slow_off_i (slow_off),
    .vis_o      (cur_vis)
  );

  cattr_cell_logic #(.DOTS(DOTS)) i_cell (
    .font_i      (md_i[DOTS-1:0]),
    .upper_i     (md_i[WORD_W-1:DOTS]),
    .disp_on_i   (disp_on_i),
    .graphic_i   (graphic_i),
    .or_mode_i   (or_mode_i),
    .attr_en_i   (attr_en_i),
    .blink_en_i  (blink_en_i),
    .blink_off_i (slow_off),
    .cursor_i    (cur_vis),
    .word_o      (word),
    .wide_o      (wide)
  );

  cattr_shifter #(.WORD_W(WORD_W), .SHORT_LEN(DOTS)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cell_load_i),
    .wide_i  (wide),
    .word_i  (word),
    .pix_o   (pix_o),
    .valid_o (pix_valid_o)
  );

  a_r11_off_light: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_load_i && !disp_on_i |=> !pix_o);
  a_r3_graphic_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_load_i && graphic_i && disp_on_i |=> pix_o == $past(md_i[WORD_W-1]));
  a_r9_cursor_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_vis |-> cur_on_i && cur_hit_i && raster_i >= cur_top_i && raster_i <= cur_bot_i);
endmodule

// File: tb/test_cattr_pixel_proc.sv
module test_cattr_pixel_proc;
  localparam int DOTS = 8, RW = 3, FB = 1, SB = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cell_load = 1'b0;
  logic [15:0]   md = '0;
  logic          disp_on = 1'b1, graphic = 1'b0, or_mode = 1'b0;
  logic          attr_en = 1'b0, blink_en = 1'b0, frame_tick = 1'b0;
  logic          cur_on = 1'b0, cur_hit = 1'b0;
  logic [1:0]    cur_mode = 2'd0;
  logic [RW-1:0] cur_top = '0, cur_bot = '0, raster = '0;
  logic          pix, pix_valid;

  int n_chk = 0, n_bad = 0, ticks = 0;
  bit done = 0;

  cattr_pixel_proc #(.DOTS(DOTS), .RASTER_W(RW), .FAST_BIT(FB), .SLOW_BIT(SB)) i_cattr_pixel_proc (
    .clk_i(clk), .rst_ni(rst_n), .cell_load_i(cell_load), .md_i(md),
    .disp_on_i(disp_on), .graphic_i(graphic), .or_mode_i(or_mode),
    .attr_en_i(attr_en), .blink_en_i(blink_en), .frame_tick_i(frame_tick),
    .cur_on_i(cur_on), .cur_hit_i(cur_hit), .cur_mode_i(cur_mode),
    .cur_top_i(cur_top), .cur_bot_i(cur_bot), .raster_i(raster),
    .pix_o(pix), .pix_valid_o(pix_valid)
  );

  function automatic bit exp_cursor();
    bit ph;
    case (cur_mode)
      2'd0: ph = 1;
      2'd1: ph = 0;
      2'd2: ph = ((ticks >> FB) & 1) == 0;
      default: ph = ((ticks >> SB) & 1) == 0;
    endcase
    return cur_on && cur_hit && raster >= cur_top && raster <= cur_bot && ph;
  endfunction

  function automatic logic [15:0] exp_word();
    logic [7:0] f, h, p;
    logic [3:0] a;
    if (graphic) return disp_on ? md : 16'h0;
    f = md[7:0];
    h = md[15:8];
    p = or_mode ? (f | h) : f;
    a = (attr_en && !or_mode) ? h[3:0] : 4'h0;
    if (a[3]) p = 8'hFF;
    else if (a[2]) p = 8'h00;
    if (a[1] && blink_en && ((ticks >> SB) & 1) == 1) p = 8'h00;
    if (a[0]) p = ~p;
    if (exp_cursor()) p = ~p;
    if (!disp_on) p = 8'h00;
    return {p, 8'h00};
  endfunction

  // called at a negedge; returns at the negedge showing the last pixel
  task automatic run_cell(input string req);
    int n;
    logic [15:0] ex, got;
    bit vbad;
    n = graphic ? 16 : 8;
    ex = exp_word();
    got = '0;
    vbad = 0;
    cell_load = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 0) cell_load = 1'b0;
      if (!pix_valid) vbad = 1;
      got = {got[14:0], pix};
    end
    if (!graphic) ex = {8'h00, ex[15:8]};
    n_chk++;
    if (got != ex || vbad) begin
      n_bad++;
      $display("FAIL %s: got %h valid_gap %0d expected %h", req, got, vbad, ex);
    end
  endtask

  task automatic idle_check(input string req);
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (pix_valid !== 1'b0 || pix !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: idle valid=%b pix=%b expected 0 0", req, pix_valid, pix);
    end
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_tick = 1'b0;
    ticks++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    n_chk++;
    if (pix_valid !== 1'b0 || pix !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset valid=%b pix=%b expected 0 0", pix_valid, pix);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1");
    // R1: blink counter zero, blinking cell visible
    attr_en = 1; blink_en = 1; md = 16'h02_C3;
    run_cell("R1");
    idle_check("R2");

    // R2, R12: plain character rows back to back
    attr_en = 0; blink_en = 0;
    for (int k = 0; k < 12; k++) begin
      md = {8'hFF, 8'(k * 37 + 1)};
      run_cell("R2/R12");
    end
    idle_check("R2");

    // R4..R7: attribute sweep over blink phases
    for (int t = 0; t < 8; t++) begin
      for (int a = 0; a < 16; a++)
        for (int e = 0; e < 4; e++) begin
          attr_en = e[0]; blink_en = e[1];
          md = {4'hA, 4'(a), 8'(8'h5A ^ (a * 17) ^ t)};
          run_cell("R4/R5/R6/R7");
        end
      tick();
    end
    attr_en = 1; blink_en = 0;

    // R8: OR merge, attribute bits ignored
    or_mode = 1;
    for (int k = 0; k < 16; k++) begin
      md = {8'(k * 29 + 15), 8'(k * 53)};
      run_cell("R8");
    end
    or_mode = 0;

    // R9, R10: cursor window and blink modes
    cur_on = 1; cur_hit = 1; md = 16'h00_96;
    for (int t = 0; t < 8; t++) begin
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int r = 0; r < 8; r++) begin
            cur_mode = 2'(m);
            raster = 3'(r);
            case (w)
              0: begin cur_top = 3'd2; cur_bot = 3'd5; end
              1: begin cur_top = 3'd5; cur_bot = 3'd2; end
              2: begin cur_top = 3'd0; cur_bot = 3'd7; end
              default: begin cur_top = 3'd3; cur_bot = 3'd3; end
            endcase
            run_cell("R9/R10");
          end
      tick();
    end
    cur_mode = 0; cur_top = 0; cur_bot = 7;
    for (int k = 0; k < 4; k++) begin
      cur_on = k[0]; cur_hit = k[1];
      run_cell("R9");
    end
    cur_on = 1; cur_hit = 1;

    // R3: graphic mode ignores attributes and cursor
    graphic = 1;
    for (int k = 0; k < 12; k++) begin
      md = 16'(k * 4099 + 16'h8E01);
      run_cell("R3");
    end
    idle_check("R3");

    // R11: display off in each mode
    disp_on = 0;
    md = 16'hFFFF;
    run_cell("R11");
    graphic = 0;
    md = 16'h08_F0;
    run_cell("R11");
    or_mode = 1;
    run_cell("R11");
    or_mode = 0;
    disp_on = 1;
    idle_check("R11");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule